// File: doc/BRIEF.md
# Enhanced Parallel Port Cycle Engine

This block runs the bus cycles of an enhanced parallel port when the host reads or writes one of its two transfer registers. One register starts an address cycle, the other a data cycle. Each cycle sets the direction line, asserts the matching strobe and then follows a full four-phase handshake with the peripheral's wait line. The host access is held off through a ready pulse until the cycle has ended.

A watchdog guards every cycle. If the peripheral does not complete the handshake within a configurable number of microseconds, counted in system clocks, the engine releases the bus, ends the host access and sets a sticky timeout flag in bit 0 of the status register. While that flag stays set, later transfer accesses finish at once and never touch the peripheral. Software clears the flag by writing a one to that bit. A software block-transfer loop that checks the flag after each byte therefore stops at the first failing byte.

Top module: `epp_cycle_engine`

## Requirements
- R1: Host offset 3 (binary 011) starts an address cycle that uses only the address strobe, and offset 4 (binary 100) starts a data cycle that uses only the data strobe. Offset 1 is the status register. Any other offset completes without a bus cycle and reads as 0.
- R2: In a transfer write, the write line is low and the data bus is driven with the host byte while the strobe is asserted. The bus is driven only while the write line is low.
- R3: In a transfer read, the write line stays high and the bus is not driven. The host receives the byte that is present on the bus when the peripheral raises wait.
- R4: The strobe is asserted until wait is seen high and is then released. The cycle ends after wait returns low, and host_ready is a pulse one clock wide. A slow peripheral only lengthens the cycle.
- R5: If the handshake has not finished within TMO_US microseconds (CLK_HZ/1e6*TMO_US clocks), the strobe, write line and bus drive are released, the access completes and the timeout flag is set. This happens whether wait never rises or never falls, no earlier than 10 us and well within 30 us at default settings.
- R6: Status bit 0 reads as the timeout flag, and it reads 0 while transfers are possible. A status write with bit 0 equal to 1 clears the flag. A write with bit 0 equal to 0 leaves it unchanged.
- R7: While the flag is set, transfer accesses complete within two clocks without any strobe. Transfer reads then return 8'hFF.
- R8: After reset, all strobes and the write line are high, the bus is not driven, host_ready is low and the flag is clear.
- R9: The address strobe and the data strobe are never asserted together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_req | input | 1 | Host access request, held until host_ready |
| host_we | input | 1 | 1 = host write, 0 = host read |
| host_addr | input | AW | Register offset |
| host_wdata | input | DW | Host write byte |
| host_rdata | output | DW | Host read byte, valid with host_ready |
| host_ready | output | 1 | One-clock completion pulse |
| pp_write_n | output | 1 | Direction line, low for host writes |
| pp_astrobe_n | output | 1 | Address strobe, active low |
| pp_dstrobe_n | output | 1 | Data strobe, active low |
| pp_wait | input | 1 | Peripheral handshake line |
| pd_out | output | DW | Bus value driven for writes |
| pd_oe | output | 1 | Bus drive enable |
| pd_in | input | DW | Bus value sampled for reads |

## Verification
The assertions assume that the host holds host_req, host_we, host_addr and host_wdata steady from the clock where it raises the request until it sees host_ready, and that it drops the request right after that pulse. They also assume that pp_wait is synchronous to clk. The bench drives every host access through a single task that changes the request fields only on falling edges and releases them in the cycle of the ready pulse. Its peripheral model moves wait only on falling edges, so the engine always sees a settled level.

// File: rtl/epp_cyc_pkg.sv
package epp_cyc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_STROBE,
    ST_RELEASE,
    ST_DONE
  } epp_state_e;

  localparam logic [2:0] OFS_STATUS = 3'd1;
  localparam logic [2:0] OFS_XADDR  = 3'd3;
  localparam logic [2:0] OFS_XDATA  = 3'd4;
endpackage

// File: rtl/epp_watchdog.sv
module epp_watchdog #(
  parameter int LIMIT = 500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic run,
  output logic expired
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = clr || (run && (cnt_q != LAST));
    cnt_d  = clr ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expired = run && (cnt_q == LAST);
endmodule

// File: rtl/epp_status_flag.sv
module epp_status_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic flag
);
  logic flag_d, flag_en;

  always_comb begin
    flag_en = set || clr;
    flag_d  = set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag <= 1'b0;
    else if (flag_en) flag <= flag_d;
  end
endmodule

// File: rtl/epp_cycle_fsm.sv
module epp_cycle_fsm
  import epp_cyc_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          req_we,
  input  logic          is_xfer,
  input  logic          is_addr,
  input  logic          blocked,
  input  logic [DW-1:0] wdata,
  input  logic          pp_wait,
  input  logic [DW-1:0] pd_in,
  input  logic          expired,
  output logic          accept,
  output logic          done,
  output logic          tmo_event,
  output logic          wd_clr,
  output logic          wd_run,
  output logic [DW-1:0] rbyte,
  output logic          pp_write_n,
  output logic          pp_astrobe_n,
  output logic          pp_dstrobe_n,
  output logic [DW-1:0] pd_out,
  output logic          pd_oe
);
  localparam logic [DW-1:0] FLOAT_BYTE = '1;

  epp_state_e    state_q, state_d;
  logic          wr_q, wr_d, adr_q, adr_d;
  logic          wn_q, wn_d, as_q, as_d, ds_q, ds_d, oe_q, oe_d;
  logic [DW-1:0] dout_q, dout_d, rbyte_q, rbyte_d;

  always_comb begin
    state_d   = state_q;
    wr_d      = wr_q;
    adr_d     = adr_q;
    wn_d      = wn_q;
    as_d      = as_q;
    ds_d      = ds_q;
    oe_d      = oe_q;
    dout_d    = dout_q;
    rbyte_d   = rbyte_q;
    tmo_event = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (req) begin
          if (is_xfer && !blocked) begin
            state_d = ST_SETUP;
            wr_d    = req_we;
            adr_d   = is_addr;
            wn_d    = !req_we;
            oe_d    = req_we;
            dout_d  = wdata;
          end else begin
            state_d = ST_DONE;
            if (is_xfer && !req_we) rbyte_d = FLOAT_BYTE;
          end
        end
      end
      ST_SETUP: begin
        state_d = ST_STROBE;
        as_d    = !adr_q;
        ds_d    = adr_q;
      end
      ST_STROBE: begin
        if (pp_wait) begin
          state_d = ST_RELEASE;
          as_d    = 1'b1;
          ds_d    = 1'b1;
          if (!wr_q) rbyte_d = pd_in;
        end else if (expired) begin
          state_d   = ST_DONE;
          tmo_event = 1'b1;
          as_d      = 1'b1;
          ds_d      = 1'b1;
          wn_d      = 1'b1;
          oe_d      = 1'b0;
          if (!wr_q) rbyte_d = FLOAT_BYTE;
        end
      end
      ST_RELEASE: begin
        if (!pp_wait) begin
          state_d = ST_DONE;
          wn_d    = 1'b1;
          oe_d    = 1'b0;
        end else if (expired) begin
          state_d   = ST_DONE;
          tmo_event = 1'b1;
          wn_d      = 1'b1;
          oe_d      = 1'b0;
        end
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      wr_q    <= 1'b0;
      adr_q   <= 1'b0;
      wn_q    <= 1'b1;
      as_q    <= 1'b1;
      ds_q    <= 1'b1;
      oe_q    <= 1'b0;
      dout_q  <= '0;
      rbyte_q <= '0;
    end else begin
      state_q <= state_d;
      wr_q    <= wr_d;
      adr_q   <= adr_d;
      wn_q    <= wn_d;
      as_q    <= as_d;
      ds_q    <= ds_d;
      oe_q    <= oe_d;
      dout_q  <= dout_d;
      rbyte_q <= rbyte_d;
    end
  end

  assign accept       = (state_q == ST_IDLE) && req;
  assign done         = (state_q == ST_DONE);
  assign wd_clr       = (state_q == ST_SETUP);
  assign wd_run       = (state_q == ST_STROBE) || (state_q == ST_RELEASE);
  assign rbyte        = rbyte_q;
  assign pp_write_n   = wn_q;
  assign pp_astrobe_n = as_q;
  assign pp_dstrobe_n = ds_q;
  assign pd_out       = dout_q;
  assign pd_oe        = oe_q;
endmodule

// File: rtl/epp_cycle_engine.sv
module epp_cycle_engine
  import epp_cyc_pkg::*;
#(
  parameter int CLK_HZ = 50_000_000,
  parameter int TMO_US = 10,
  parameter int DW     = 8,
  parameter int AW     = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_req,
  input  logic          host_we,
  input  logic [AW-1:0] host_addr,
  input  logic [DW-1:0] host_wdata,
  output logic [DW-1:0] host_rdata,
  output logic          host_ready,
  output logic          pp_write_n,
  output logic          pp_astrobe_n,
  output logic          pp_dstrobe_n,
  input  logic          pp_wait,
  output logic [DW-1:0] pd_out,
  output logic          pd_oe,
  input  logic [DW-1:0] pd_in
);
  localparam int TMO_CYC = (CLK_HZ / 1_000_000) * TMO_US;

  logic          is_xfer, is_addr, is_stat;
  logic          accept, tmo_event, wd_clr, wd_run, expired;
  logic          tmo_flag, stat_clr;
  logic [DW-1:0] rbyte;
  logic [31:0]   tmo_lim;

  assign tmo_lim  = 32'(TMO_CYC);
  assign is_addr  = (host_addr == AW'(OFS_XADDR));
  assign is_xfer  = is_addr || (host_addr == AW'(OFS_XDATA));
  assign is_stat  = (host_addr == AW'(OFS_STATUS));
  assign stat_clr = accept && host_we && is_stat && host_wdata[0];

  epp_cycle_fsm #(.DW(DW)) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .req          (host_req),
    .req_we       (host_we),
    .is_xfer      (is_xfer),
    .is_addr      (is_addr),
    .blocked      (tmo_flag),
    .wdata        (host_wdata),
    .pp_wait      (pp_wait),
    .pd_in        (pd_in),
    .expired      (expired),
    .accept       (accept),
    .done         (host_ready),
    .tmo_event    (tmo_event),
    .wd_clr       (wd_clr),
    .wd_run       (wd_run),
    .rbyte        (rbyte),
    .pp_write_n   (pp_write_n),
    .pp_astrobe_n (pp_astrobe_n),
    .pp_dstrobe_n (pp_dstrobe_n),
    .pd_out       (pd_out),
    .pd_oe        (pd_oe)
  );

  epp_watchdog #(.LIMIT(TMO_CYC)) u_wdog (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (wd_clr),
    .run     (wd_run),
    .expired (expired)
  );

  epp_status_flag u_flag (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (tmo_event),
    .clr   (stat_clr),
    .flag  (tmo_flag)
  );

  always_comb begin
    if (is_stat)      host_rdata = {{(DW-1){1'b0}}, tmo_flag};
    else if (is_xfer) host_rdata = rbyte;
    else              host_rdata = '0;
  end
endmodule

// File: rtl/epp_cycle_engine_chk.sv
module epp_cycle_engine_chk #(
  parameter int DW = 8,
  parameter int AW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          host_req,
  input logic          host_we,
  input logic [AW-1:0] host_addr,
  input logic [DW-1:0] host_wdata,
  input logic          host_ready,
  input logic          pp_write_n,
  input logic          pp_astrobe_n,
  input logic          pp_dstrobe_n,
  input logic          pd_oe,
  input logic          tmo_flag,
  input logic [31:0]   tmo_lim
);
  logic [31:0] strb_run;
  logic        clr_try;

  assign clr_try = host_req && host_we && (host_addr == AW'(1)) && host_wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                             strb_run <= '0;
    else if (!pp_astrobe_n || !pp_dstrobe_n) strb_run <= strb_run + 1;
    else                                    strb_run <= '0;
  end

  // R9
  strb_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pp_astrobe_n || pp_dstrobe_n);

  // R2
  oe_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pd_oe |-> !pp_write_n);

  // R4
  rdy_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_ready |=> !host_ready);

  // R7
  blk_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_flag |-> (pp_astrobe_n && pp_dstrobe_n));

  // R6
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo_flag && !clr_try) |=> tmo_flag);

  // R5
  strb_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strb_run <= tmo_lim);
endmodule

bind epp_cycle_engine epp_cycle_engine_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .host_req     (host_req),
  .host_we      (host_we),
  .host_addr    (host_addr),
  .host_wdata   (host_wdata),
  .host_ready   (host_ready),
  .pp_write_n   (pp_write_n),
  .pp_astrobe_n (pp_astrobe_n),
  .pp_dstrobe_n (pp_dstrobe_n),
  .pd_oe        (pd_oe),
  .tmo_flag     (tmo_flag),
  .tmo_lim      (tmo_lim)
);

// File: tb/sim_epp_cycle_engine.sv
module sim_epp_cycle_engine;
  logic       clk, rst_n;
  logic       host_req, host_we;
  logic [2:0] host_addr;
  logic [7:0] host_wdata, host_rdata;
  logic       host_ready;
  logic       pp_write_n, pp_astrobe_n, pp_dstrobe_n, pp_wait;
  logic [7:0] pd_out, pd_in;
  logic       pd_oe;

  int checks = 0;
  int errors = 0;

  // peripheral model state
  logic       resp_en, stuck;
  int         delay, dly_cnt;
  logic [7:0] got_byte;
  logic       got_oe, got_wn_low;
  int         afalls, dfalls;
  logic       pa, pdd;

  epp_cycle_engine u0 (
    .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_we(host_we),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .host_ready(host_ready), .pp_write_n(pp_write_n), .pp_astrobe_n(pp_astrobe_n),
    .pp_dstrobe_n(pp_dstrobe_n), .pp_wait(pp_wait), .pd_out(pd_out),
    .pd_oe(pd_oe), .pd_in(pd_in)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(negedge clk) begin
    if (!rst_n) begin
      pp_wait = 1'b0; dly_cnt = 0; afalls = 0; dfalls = 0; pa = 1'b1; pdd = 1'b1;
    end else begin
      if (pa && !pp_astrobe_n) afalls++;
      if (pdd && !pp_dstrobe_n) dfalls++;
      pa = pp_astrobe_n; pdd = pp_dstrobe_n;
      if (!pp_astrobe_n || !pp_dstrobe_n) begin
        if (resp_en) begin
          if (dly_cnt >= delay) begin
            if (!pp_wait) begin
              got_byte = pd_out; got_oe = pd_oe; got_wn_low = !pp_write_n;
            end
            pp_wait = 1'b1;
          end else dly_cnt++;
        end
      end else begin
        dly_cnt = 0;
        if (!stuck) pp_wait = 1'b0;
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic acc(input bit we, input logic [2:0] a, input logic [7:0] d,
                     output logic [7:0] rd, output int cyc);
    @(negedge clk);
    host_req = 1'b1; host_we = we; host_addr = a; host_wdata = d;
    cyc = 0;
    do begin
      @(negedge clk);
      cyc++;
    end while (!host_ready && cyc < 3000);
    rd = host_rdata;
    host_req = 1'b0; host_we = 1'b0;
    @(negedge clk);
    chk("R4 ready one clock", {31'b0, host_ready}, 32'd0);
  endtask

  function automatic logic [31:0] in_rng(int v, int lo, int hi);
    return (v >= lo && v <= hi) ? 32'd1 : 32'd0;
  endfunction

  task automatic t_reset;
    logic [7:0] rd; int cyc;
    chk("R8 astrobe idle", {31'b0, pp_astrobe_n}, 32'd1);
    chk("R8 dstrobe idle", {31'b0, pp_dstrobe_n}, 32'd1);
    chk("R8 write idle", {31'b0, pp_write_n}, 32'd1);
    chk("R8 no drive", {31'b0, pd_oe}, 32'd0);
    chk("R8 ready low", {31'b0, host_ready}, 32'd0);
    acc(1'b0, 3'd1, 8'h00, rd, cyc);
    chk("R6 R8 flag clear", {24'b0, rd}, 32'd0);
  endtask

  task automatic t_write(input logic [2:0] a, input logic [7:0] d);
    logic [7:0] rd; int cyc; int a0, d0;
    a0 = afalls; d0 = dfalls; got_byte = 8'h00; got_oe = 0; got_wn_low = 0;
    acc(1'b1, a, d, rd, cyc);
    chk("R2 byte on bus", {24'b0, got_byte}, {24'b0, d});
    chk("R2 bus driven", {31'b0, got_oe}, 32'd1);
    chk("R2 write low", {31'b0, got_wn_low}, 32'd1);
    chk("R1 addr strobe count", afalls - a0, (a == 3'd3) ? 32'd1 : 32'd0);
    chk("R1 data strobe count", dfalls - d0, (a == 3'd4) ? 32'd1 : 32'd0);
    chk("R4 strobes released", {30'b0, pp_astrobe_n, pp_dstrobe_n}, 32'd3);
    chk("R2 drive released", {31'b0, pd_oe}, 32'd0);
  endtask

  task automatic t_read(input logic [2:0] a, input logic [7:0] d);
    logic [7:0] rd; int cyc; int a0, d0;
    a0 = afalls; d0 = dfalls; pd_in = d; got_oe = 1; got_wn_low = 1;
    acc(1'b0, a, 8'h00, rd, cyc);
    chk("R3 read byte", {24'b0, rd}, {24'b0, d});
    chk("R3 no drive on read", {31'b0, got_oe}, 32'd0);
    chk("R3 write high on read", {31'b0, got_wn_low}, 32'd0);
    chk("R1 read strobe kind", (afalls - a0) * 2 + (dfalls - d0),
        (a == 3'd3) ? 32'd2 : 32'd1);
  endtask

  task automatic t_other;
    logic [7:0] rd; int cyc; int s0;
    s0 = afalls + dfalls;
    acc(1'b1, 3'd0, 8'h5A, rd, cyc);
    acc(1'b0, 3'd6, 8'h00, rd, cyc);
    chk("R1 other offset reads 0", {24'b0, rd}, 32'd0);
    chk("R1 other offset no strobe", afalls + dfalls - s0, 32'd0);
    chk("R1 other offset fast", in_rng(cyc, 1, 2), 32'd1);
  endtask

  task automatic t_slow;
    logic [7:0] rd; int cyc;
    delay = 20; pd_in = 8'h3C;
    acc(1'b0, 3'd4, 8'h00, rd, cyc);
    chk("R4 slow read byte", {24'b0, rd}, 32'h3C);
    chk("R4 slow latency", in_rng(cyc, 21, 40), 32'd1);
    acc(1'b0, 3'd1, 8'h00, rd, cyc);
    chk("R4 slow no timeout", {24'b0, rd}, 32'd0);
    delay = 0;
  endtask

  task automatic t_timeout;
    logic [7:0] rd; int cyc;
    resp_en = 1'b0;
    acc(1'b0, 3'd4, 8'h00, rd, cyc);
    chk("R5 timeout window 10..30us", in_rng(cyc, 500, 1500), 32'd1);
    chk("R5 strobes released", {30'b0, pp_astrobe_n, pp_dstrobe_n}, 32'd3);
    chk("R5 write line released", {31'b0, pp_write_n}, 32'd1);
    acc(1'b0, 3'd1, 8'h00, rd, cyc);
    chk("R5 R6 flag set", {24'b0, rd}, 32'd1);
    resp_en = 1'b1;
  endtask

  task automatic t_blocked;
    logic [7:0] rd; int cyc; int s0;
    s0 = afalls + dfalls; pd_in = 8'h11;
    acc(1'b0, 3'd4, 8'h00, rd, cyc);
    chk("R7 blocked read value", {24'b0, rd}, 32'hFF);
    chk("R7 blocked fast", in_rng(cyc, 1, 2), 32'd1);
    acc(1'b1, 3'd3, 8'h77, rd, cyc);
    chk("R7 blocked no strobe", afalls + dfalls - s0, 32'd0);
  endtask

  task automatic t_clear;
    logic [7:0] rd; int cyc;
    acc(1'b1, 3'd1, 8'hFE, rd, cyc);
    acc(1'b0, 3'd1, 8'h00, rd, cyc);
    chk("R6 write 0 keeps flag", {24'b0, rd}, 32'd1);
    acc(1'b1, 3'd1, 8'h01, rd, cyc);
    acc(1'b0, 3'd1, 8'h00, rd, cyc);
    chk("R6 write 1 clears flag", {24'b0, rd}, 32'd0);
    t_read(3'd4, 8'h96);
  endtask

  task automatic t_stuck;
    logic [7:0] rd; int cyc;
    stuck = 1'b1;
    acc(1'b1, 3'd4, 8'h42, rd, cyc);
    chk("R5 stuck wait window", in_rng(cyc, 500, 1500), 32'd1);
    acc(1'b0, 3'd1, 8'h00, rd, cyc);
    chk("R5 stuck wait flag", {24'b0, rd}, 32'd1);
    stuck = 1'b0;
    repeat (2) @(negedge clk);
    acc(1'b1, 3'd1, 8'h01, rd, cyc);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    rst_n = 1'b0; host_req = 1'b0; host_we = 1'b0; host_addr = 3'd0;
    host_wdata = 8'h00; pd_in = 8'h00; resp_en = 1'b1; stuck = 1'b0; delay = 0;
    got_byte = 8'h00; got_oe = 1'b0; got_wn_low = 1'b0; pp_wait = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_write(3'd4, 8'hA5);
    t_write(3'd3, 8'h5A);
    t_read(3'd4, 8'hC3);
    t_read(3'd3, 8'h0F);
    t_other();
    t_slow();
    t_timeout();
    t_blocked();
    t_clear();
    t_stuck();
    t_write(3'd4, 8'h81);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule